// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Armed External Counting

This block is a sixteen-bit up-counter. It takes its count events from one of two sources. The first is an internal tick enable that is synchronous to the system clock. The second is the rising edges of an external clock pin. When the count goes past its top value it returns to zero and sets a sticky overflow flag. A chain of enable inputs gates that flag into an interrupt request. The same flag, during sleep, produces a wake request that does not depend on the global enable. Software can load either byte of the count on its own. A compare unit elsewhere can send a one-cycle clear strobe that turns the counter into a period timer.

External counting runs through a small state machine. After the counter is switched on in external mode, the count does not move until the pin has been seen to fall. Only the rising edges after that fall advance the count. Turning the run bit off drops this armed state. In synchronous mode the pin passes through a two-flop synchronizer. In asynchronous mode the pin is sampled once, and counting carries on through sleep.

The state machine has four states:
- ST_IDLE: the run bit is low.
- ST_INT: counting internal ticks.
- ST_WAIT_FALL: external mode, waiting for a falling edge.
- ST_EXT: external mode, armed.

Its transitions are:
- IDLE to INT, or IDLE to WAIT_FALL, when the run bit rises, chosen by the mode.
- WAIT_FALL to EXT on a qualified falling edge.
- INT to WAIT_FALL, or EXT and WAIT_FALL to INT, when the mode input changes.
- Any state back to IDLE when the run bit drops.

Top module: `evt_timer16`

## Requirements
- R1: In internal mode (ext_mode=0) with run=1 and sleep=0, the count rises by one on every clock cycle in which tick=1. It does not change when tick=0.
- R2: An increment from 16'hFFFF gives 16'h0000 and sets ovf_flag.
- R3: ovf_flag stays at 1 until a cycle with flag_clr=1. If a new overflow lands in that same cycle, the flag stays set.
- R4: irq is 1 exactly when ovf_flag, run, tmr_ie, periph_ie and global_ie are all 1.
- R5: In external mode (ext_mode=1), once run goes high no rising edge of ext_clk counts until a falling edge of ext_clk has been seen. After that, each rising edge adds one.
- R6: With run=0 the count only changes through writes or clears. After run is lowered and raised again, a new falling edge is needed before external rising edges count.
- R7: A cycle with trig_clr=1 and no byte write sets the count to 16'h0000 and does not set ovf_flag, even when the count was 16'hFFFF.
- R8: In a cycle with both a byte write and trig_clr=1, the write is applied and the clear is dropped. A write cycle never increments.
- R9: wr_lo loads wr_data into count[7:0] only. wr_hi loads wr_data into count[15:8] only.
- R10: While sleep=1, internal ticks and synchronous external edges do not count. In asynchronous external mode (async_mode=1) edges still count.
- R11: wake is 1 exactly when sleep, ovf_flag, run, tmr_ie and periph_ie are all 1, whatever global_ie is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter run bit |
| ext_mode | input | 1 | 1 selects external clock edges as the count source |
| async_mode | input | 1 | 1 selects single-sample qualification and counting during sleep |
| tick | input | 1 | Internal count enable |
| ext_clk | input | 1 | External clock pin |
| sleep | input | 1 | Sleep state from the power controller |
| wr_lo | input | 1 | Write strobe for the low count byte |
| wr_hi | input | 1 | Write strobe for the high count byte |
| wr_data | input | 8 | Byte write data |
| flag_clr | input | 1 | Software clear of the overflow flag |
| trig_clr | input | 1 | Clear strobe from the compare unit |
| tmr_ie | input | 1 | Timer interrupt enable |
| periph_ie | input | 1 | Peripheral interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| count | output | 16 | Live count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request to the sleep controller |

## Verification
The hardest case to reach from the ports is an overflow during sleep in asynchronous external mode with the global enable off. The stimulus first loads 16'hFFFF one byte at a time while the counter is stopped. It then starts the counter in external mode with the pin low. It raises the pin once, which must not count, and drops it to arm the counter. Only then does it assert sleep and give the single rising edge that wraps the count. At that point wake must be high while irq stays low.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_INT       = 2'd1,
        ST_WAIT_FALL = 2'd2,
        ST_EXT       = 2'd3
    } tmr_state_t;
endpackage

// File: rtl/evt_timer16_edge.sv
module evt_timer16_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_mode,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   sel;
    logic                   prev;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sel = async_mode ? chain[0] : chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sel;
    end

    assign rise = sel & ~prev;
    assign fall = ~sel & prev;
endmodule

// File: rtl/evt_timer16_fsm.sv
module evt_timer16_fsm
    import evt_timer16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ext_mode,
    input  logic       fall,
    output tmr_state_t state,
    output logic       src_int,
    output logic       src_ext
);
    tmr_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (run) nxt = ext_mode ? ST_WAIT_FALL : ST_INT;
            ST_INT:       if (!run) nxt = ST_IDLE;
                          else if (ext_mode) nxt = ST_WAIT_FALL;
            ST_WAIT_FALL: if (!run) nxt = ST_IDLE;
                          else if (!ext_mode) nxt = ST_INT;
                          else if (fall) nxt = ST_EXT;
            ST_EXT:       if (!run) nxt = ST_IDLE;
                          else if (!ext_mode) nxt = ST_INT;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        src_int = 1'b0;
        src_ext = 1'b0;
        unique case (state)
            ST_INT:  src_int = run & ~ext_mode;
            ST_EXT:  src_ext = run & ext_mode;
            default: ;
        endcase
    end
endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core #(
    parameter int WIDTH = 16,
    parameter int BYTE  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             trig_clr,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BYTE-1:0]  wr_data,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    logic wr_any;
    logic do_inc;
    logic wrap;

    assign wr_any = wr_lo | wr_hi;
    assign do_inc = inc & ~wr_any & ~trig_clr;
    assign wrap   = do_inc & (count == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_any) begin
            if (wr_lo) count[BYTE-1:0]     <= wr_data;
            if (wr_hi) count[WIDTH-1:BYTE] <= wr_data;
        end else if (trig_clr) begin
            count <= '0;
        end else if (do_inc) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap)     ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer16_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_mode,
    input  logic             async_mode,
    input  logic             tick,
    input  logic             ext_clk,
    input  logic             sleep,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    input  logic             flag_clr,
    input  logic             trig_clr,
    input  logic             tmr_ie,
    input  logic             periph_ie,
    input  logic             global_ie,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag,
    output logic             irq,
    output logic             wake
);
    logic       rise, fall;
    logic       src_int, src_ext;
    logic       inc;
    logic       ie_chain;
    tmr_state_t state;

    evt_timer16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode),
        .pin(ext_clk), .rise(rise), .fall(fall)
    );

    evt_timer16_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .ext_mode(ext_mode),
        .fall(fall), .state(state), .src_int(src_int), .src_ext(src_ext)
    );

    assign inc = (src_int & tick & ~sleep)
               | (src_ext & rise & (~sleep | async_mode));

    evt_timer16_core #(.WIDTH(WIDTH), .BYTE(8)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .trig_clr(trig_clr),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag)
    );

    assign ie_chain = ovf_flag & run & tmr_ie & periph_ie;
    assign irq      = ie_chain & global_ie;
    assign wake     = ie_chain & sleep;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             sleep,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic [7:0]       wr_data,
    input logic             flag_clr,
    input logic             trig_clr,
    input logic             tmr_ie,
    input logic             periph_ie,
    input logic             global_ie,
    input logic [WIDTH-1:0] count,
    input logic             ovf_flag,
    input logic             irq,
    input logic             wake
);
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == {WIDTH{1'b1}} && count == '0 && !$past(trig_clr)
         && !$past(wr_lo) && !$past(wr_hi)) |-> ovf_flag); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag); // R3
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && run && tmr_ie && periph_ie && global_ie)); // R4
    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi && !trig_clr) |=> $stable(count)); // R6
    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clr && !wr_lo && !wr_hi) |=> (count == '0)); // R7
    AST_TRIG_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clr && !ovf_flag) |=> !ovf_flag); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[7:0] == $past(wr_data))); // R8
    AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (sleep && ovf_flag && run && tmr_ie && periph_ie)); // R11
endmodule

bind evt_timer16 evt_timer16_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .sleep(sleep), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .flag_clr(flag_clr), .trig_clr(trig_clr),
    .tmr_ie(tmr_ie), .periph_ie(periph_ie), .global_ie(global_ie),
    .count(count), .ovf_flag(ovf_flag), .irq(irq), .wake(wake)
);

// File: tb/tb_evt_timer16.sv
module tb_evt_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 0, ext_mode = 0, async_mode = 0, tick = 0, ext_clk = 0, sleep = 0;
    logic        wr_lo = 0, wr_hi = 0, flag_clr = 0, trig_clr = 0;
    logic        tmr_ie = 0, periph_ie = 0, global_ie = 0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count;
    logic        ovf_flag, irq, wake;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    evt_timer16 dut (
        .clk(clk), .rst_n(rst_n), .run(run), .ext_mode(ext_mode),
        .async_mode(async_mode), .tick(tick), .ext_clk(ext_clk), .sleep(sleep),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .flag_clr(flag_clr),
        .trig_clr(trig_clr), .tmr_ie(tmr_ie), .periph_ie(periph_ie),
        .global_ie(global_ie), .count(count), .ovf_flag(ovf_flag),
        .irq(irq), .wake(wake)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(logic [15:0] v);
        @(negedge clk); wr_lo = 1; wr_data = v[7:0];
        @(negedge clk); wr_lo = 0; wr_hi = 1; wr_data = v[15:8];
        @(negedge clk); wr_hi = 0;
    endtask

    task automatic ticks(int n);
        @(negedge clk); tick = 1;
        repeat (n) @(negedge clk);
        tick = 0;
    endtask

    task automatic pin(logic v);
        @(negedge clk); ext_clk = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic clr_flag();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 reset count", count, 16'h0);
        check("R3 reset flag", {15'b0, ovf_flag}, 16'h0);
        check("R4 reset irq", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_internal();
        @(negedge clk); run = 1;
        ticks(5);
        check("R1 five ticks", count, 16'd5);
        repeat (4) @(negedge clk);
        check("R1 idle no tick", count, 16'd5);
    endtask

    task automatic t_wrap_flag();
        write_word(16'hFFFE);
        check("R9 word load", count, 16'hFFFE);
        ticks(2);
        check("R2 wrap count", count, 16'h0000);
        check("R2 flag set", {15'b0, ovf_flag}, 16'h1);
        ticks(3);
        check("R3 flag sticky", {15'b0, ovf_flag}, 16'h1);
        clr_flag();
        check("R3 flag cleared", {15'b0, ovf_flag}, 16'h0);
    endtask

    task automatic t_irq_chain();
        write_word(16'hFFFF);
        ticks(1);
        @(negedge clk);
        check("R4 no enables", {15'b0, irq}, 16'h0);
        tmr_ie = 1; periph_ie = 1; @(negedge clk);
        check("R4 global off", {15'b0, irq}, 16'h0);
        global_ie = 1; @(negedge clk);
        check("R4 all on", {15'b0, irq}, 16'h1);
        periph_ie = 0; @(negedge clk);
        check("R4 periph off", {15'b0, irq}, 16'h0);
        periph_ie = 1; clr_flag();
        check("R4 flag clear drops irq", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_bytes_trig();
        write_word(16'h1234);
        @(negedge clk); wr_hi = 1; wr_data = 8'hAB;
        @(negedge clk); wr_hi = 0;
        check("R9 high only", count, 16'hAB34);
        @(negedge clk); wr_lo = 1; wr_data = 8'h5A; trig_clr = 1;
        @(negedge clk); wr_lo = 0; trig_clr = 0;
        check("R8 write beats clear", count, 16'hAB5A);
        write_word(16'hFFFF);
        @(negedge clk); trig_clr = 1; tick = 1;
        @(negedge clk); trig_clr = 0; tick = 0;
        check("R7 clear to zero", count, 16'h0);
        check("R7 no flag", {15'b0, ovf_flag}, 16'h0);
        @(negedge clk); wr_lo = 1; wr_data = 8'h07; tick = 1;
        @(negedge clk); wr_lo = 0; tick = 0;
        check("R8 write no inc", count, 16'h0007);
    endtask

    task automatic t_ext_arm();
        @(negedge clk); run = 0; ext_clk = 0;
        write_word(16'h0000);
        @(negedge clk); ext_mode = 1; run = 1;
        pin(1);
        check("R5 first rise ignored", count, 16'h0);
        pin(0); pin(1);
        check("R5 armed rise", count, 16'h1);
        pin(0); pin(1);
        check("R5 second rise", count, 16'h2);
        pin(0);
        @(negedge clk); run = 0;
        pin(1); pin(0);
        check("R6 frozen when off", count, 16'h2);
        @(negedge clk); run = 1;
        pin(1);
        check("R6 rearm needed", count, 16'h2);
        pin(0); pin(1);
        check("R6 after rearm", count, 16'h3);
        pin(0);
    endtask

    task automatic t_sleep();
        @(negedge clk); ext_mode = 0; sleep = 1;
        ticks(3);
        check("R10 internal sleeps", count, 16'h3);
        @(negedge clk); sleep = 0; run = 0; global_ie = 0;
        write_word(16'hFFFF);
        clr_flag();
        @(negedge clk); ext_mode = 1; async_mode = 1; run = 1;
        pin(1); pin(0);
        @(negedge clk); sleep = 1;
        pin(1);
        check("R10 async counts asleep", count, 16'h0);
        check("R11 wake raised", {15'b0, wake}, 16'h1);
        check("R11 irq held off", {15'b0, irq}, 16'h0);
        @(negedge clk); global_ie = 1; @(negedge clk);
        check("R4 irq with global", {15'b0, irq}, 16'h1);
        @(negedge clk); sleep = 0; @(negedge clk);
        check("R11 wake needs sleep", {15'b0, wake}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_internal();
        t_wrap_flag();
        t_irq_chain();
        t_bytes_trig();
        t_ext_arm();
        t_sleep();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule